// File: doc/BRIEF.md
# Polled Register-Mapped Asynchronous Serial Port

This block is a memory-mapped asynchronous serial port. Software sees ten 32-bit registers on a simple single-cycle bus. Writes are strobed by `wr_en`. Reads are combinational from `addr`, and a read's side effects take hold at the clock edge that ends the `rd_en` cycle. The bus address is a word index, which is the byte offset divided by four.

A baud divider produces a tick every `reload + 1` clocks while the run bit is set. Every serial bit lasts 16 ticks. The transmitter has a one-entry holding buffer that feeds a shift register. The receiver synchronises the line, then samples each bit at its middle and places the byte in a one-entry receive buffer. Software polls status bits to learn when it may write a byte and when a byte is waiting.

Word indices: 0 baud reload, 1 TX buffer (write), 2 RX buffer (read), 3 control, 4 interrupt enable, 5 status, 6 guard time, 7 timeout, 8 TX buffer reset, 9 RX buffer reset. Interrupt enable, guard time and timeout are placeholders: they read as zero and ignore writes.

Top module: `sp_serial_port`

## Requirements
- R1: The baud register (index 0) reads back its written value in the low `BAUD_W` bits. The control register (index 3) reads back only bits 8, 7, 5, 3 and 2..0 of the written value; every other bit reads zero. Indices 4, 6 and 7 read as zero.
- R2: After reset, baud, control and status (index 5) all read zero, and `tx_o` is high.
- R3: A transmitted frame has these bits in order: a low start bit, eight data bits LSB first, an odd-parity bit when control bit 5 is set (so that data plus parity hold an odd number of ones), and a high stop bit. Each bit lasts 16 ticks, so it lasts 32 clocks when reload is 1.
- R4: Status bit 9 is set while the TX holding buffer is occupied. A write to index 1 while bit 9 is set is ignored, and that byte is never sent.
- R5: Writing a value with bit 0 set to index 8 empties the TX holding buffer and clears status bit 9. The byte that was held is never transmitted.
- R6: While control bit 7 (run) is clear, no frame starts and `tx_o` stays high. A written byte waits in the holding buffer and is sent once run is set.
- R7: With control bit 8 set, a received frame places its byte at index 2 and sets status bit 0. When control bit 5 is set, the receiver expects a parity bit between the data and the stop bit.
- R8: A low pulse on `rx_i` that is back high by the middle of the start bit is rejected: status bit 0 stays clear.
- R9: A read of index 2 clears status bit 0 and status bit 4.
- R10: A frame that completes while status bit 0 is set replaces the buffered byte and sets status bit 4 (overrun).
- R11: While control bit 8 is clear, incoming frames are ignored and status bit 0 stays clear.
- R12: Writing a value with bit 0 set to index 9 clears status bits 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | ADDR_W | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tx_o | output | 1 | Serial transmit line, idle high |
| rx_i | input | 1 | Serial receive line, idle high |

## Verification
The hardest receive conditions to reach are a start pulse that ends before mid-bit and a second frame that completes before software drains the first. The bench therefore drives `rx_i` itself with bit-exact timing at 32 clocks per bit. It sends an 8-clock low glitch, and it sends back-to-back frames with no read between them. On the transmit side, the full-buffer rejection and the reset strobe only show up while a frame is in flight. For that reason, writes are issued in consecutive bus cycles, and a line monitor compares every frame against a queue of expected bytes.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int BUS_W = 32;
   // register word indices
   localparam int W_BAUD  = 0;
   localparam int W_TXBUF = 1;
   localparam int W_RXBUF = 2;
   localparam int W_CTRL  = 3;
   localparam int W_STAT  = 5;
   localparam int W_TXRST = 8;
   localparam int W_RXRST = 9;
   // control bit positions
   localparam int CB_RXEN = 8;
   localparam int CB_RUN  = 7;
   localparam int CB_PODD = 5;
   localparam logic [BUS_W-1:0] CTL_MASK = 32'h0000_01AF;
   // status bit positions
   localparam int ST_RXFULL = 0;
   localparam int ST_OVR    = 4;
   localparam int ST_TXFULL = 9;
endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen #(
   parameter int BAUD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [BAUD_W-1:0] reload,
   output logic              tick
);
   logic [BAUD_W-1:0] cnt_q;
   logic              wrap;

   assign wrap = (cnt_q >= reload);
   assign tick = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (wrap)   cnt_q <= '0;
      else             cnt_q <= cnt_q + BAUD_W'(1);
   end
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic       par_en,
   input  logic       ld_valid,
   input  logic [7:0] ld_data,
   output logic       ld_take,
   output logic       busy,
   output logic       tx_o
);
   localparam int TW = $clog2(OVERSAMPLE);
   localparam logic [TW-1:0] LAST_TICK = TW'(OVERSAMPLE - 1);

   logic [10:0]   shreg_q;
   logic [3:0]    left_q;
   logic [TW-1:0] tcnt_q;

   assign ld_take = ld_valid && run && !busy;
   assign tx_o    = busy ? shreg_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         shreg_q <= '1;
         left_q  <= '0;
         tcnt_q  <= '0;
      end else if (ld_take) begin
         busy    <= 1'b1;
         shreg_q <= {1'b1, (par_en ? ~^ld_data : 1'b1), ld_data, 1'b0};
         left_q  <= par_en ? 4'd11 : 4'd10;
         tcnt_q  <= '0;
      end else if (busy && tick) begin
         if (tcnt_q == LAST_TICK) begin
            tcnt_q <= '0;
            if (left_q == 4'd1) begin
               busy <= 1'b0;
            end else begin
               left_q  <= left_q - 4'd1;
               shreg_q <= {1'b1, shreg_q[10:1]};
            end
         end else begin
            tcnt_q <= tcnt_q + TW'(1);
         end
      end
   end
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       par_en,
   input  logic       rx_i,
   output logic       commit,
   output logic [7:0] data
);
   localparam int TW = $clog2(OVERSAMPLE);
   localparam logic [TW-1:0] MID_TICK = TW'(OVERSAMPLE / 2 - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rxs;
   logic                   busy_q;
   logic [TW-1:0]          tcnt_q;
   logic [3:0]             bidx_q;
   logic [3:0]             stop_idx;
   logic [7:0]             dsh_q;

   assign rxs      = sync_q[SYNC_STAGES-1];
   assign stop_idx = par_en ? 4'd10 : 4'd9;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else        sync_q[s] <= (s == 0) ? rx_i : sync_q[(s == 0) ? 0 : s - 1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tcnt_q <= '0;
         bidx_q <= '0;
         dsh_q  <= '0;
         data   <= '0;
         commit <= 1'b0;
      end else if (!en) begin
         busy_q <= 1'b0;
         commit <= 1'b0;
      end else begin
         commit <= 1'b0;
         if (tick) begin
            if (!busy_q) begin
               if (!rxs) begin
                  busy_q <= 1'b1;
                  tcnt_q <= '0;
                  bidx_q <= '0;
               end
            end else begin
               tcnt_q <= tcnt_q + TW'(1);
               if (tcnt_q == MID_TICK) begin
                  bidx_q <= bidx_q + 4'd1;
                  if (bidx_q == 4'd0) begin
                     if (rxs) busy_q <= 1'b0;
                  end else if (bidx_q <= 4'd8) begin
                     dsh_q <= {rxs, dsh_q[7:1]};
                  end
                  if (bidx_q == stop_idx) begin
                     busy_q <= 1'b0;
                     commit <= 1'b1;
                     data   <= dsh_q;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/sp_serial_port.sv
module sp_serial_port
   import sp_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int BAUD_W      = 16,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PARITY_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              tx_o,
   input  logic              rx_i
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("sp_serial_port: ADDR_W must cover ten registers");
      end
      if (BAUD_W < 1 || BAUD_W > BUS_W) begin : g_bad_baud
         $error("sp_serial_port: BAUD_W out of range");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("sp_serial_port: OVERSAMPLE must be a power of two >= 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sp_serial_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BAUD_W-1:0] baud_q;
   logic [BUS_W-1:0]  ctrl_q;
   logic              run, rx_en, par_en, tick;
   logic              hold_full, ld_take, tx_busy;
   logic [7:0]        hold_data;
   logic              rx_commit, rx_full, ovr;
   logic [7:0]        rx_new, rx_data;
   logic              wr_baud, wr_tx, wr_ctrl, wr_txrst, wr_rxrst, rd_rx;

   assign run   = ctrl_q[CB_RUN];
   assign rx_en = ctrl_q[CB_RXEN];

   generate
      if (PARITY_EN) begin : g_par
         assign par_en = ctrl_q[CB_PODD];
      end else begin : g_nopar
         assign par_en = 1'b0;
      end
   endgenerate

   assign wr_baud  = wr_en && (addr == ADDR_W'(W_BAUD));
   assign wr_tx    = wr_en && (addr == ADDR_W'(W_TXBUF));
   assign wr_ctrl  = wr_en && (addr == ADDR_W'(W_CTRL));
   assign wr_txrst = wr_en && (addr == ADDR_W'(W_TXRST)) && wdata[0];
   assign wr_rxrst = wr_en && (addr == ADDR_W'(W_RXRST)) && wdata[0];
   assign rd_rx    = rd_en && (addr == ADDR_W'(W_RXBUF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         baud_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_baud) baud_q <= wdata[BAUD_W-1:0];
         if (wr_ctrl) ctrl_q <= wdata & CTL_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (wr_txrst) begin
         hold_full <= 1'b0;
      end else if (wr_tx && !hold_full) begin
         hold_full <= 1'b1;
         hold_data <= wdata[7:0];
      end else if (ld_take) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         ovr     <= 1'b0;
         rx_data <= '0;
      end else if (wr_rxrst) begin
         rx_full <= 1'b0;
         ovr     <= 1'b0;
      end else if (rx_commit) begin
         rx_data <= rx_new;
         rx_full <= 1'b1;
         if (rx_full && !rd_rx) ovr <= 1'b1;
      end else if (rd_rx) begin
         rx_full <= 1'b0;
         ovr     <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(W_BAUD))       rdata = BUS_W'(baud_q);
      else if (addr == ADDR_W'(W_RXBUF)) rdata = BUS_W'(rx_data);
      else if (addr == ADDR_W'(W_CTRL))  rdata = ctrl_q;
      else if (addr == ADDR_W'(W_STAT)) begin
         rdata[ST_RXFULL] = rx_full;
         rdata[ST_OVR]    = ovr;
         rdata[ST_TXFULL] = hold_full;
      end
   end

   sp_tick_gen #(.BAUD_W(BAUD_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .reload(baud_q), .tick(tick)
   );

   sp_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .par_en(par_en),
      .ld_valid(hold_full), .ld_data(hold_data), .ld_take(ld_take),
      .busy(tx_busy), .tx_o(tx_o)
   );

   sp_rx #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .par_en(par_en),
      .rx_i(rx_i), .commit(rx_commit), .data(rx_new)
   );
endmodule

// File: rtl/sp_serial_port_chk.sv
module sp_serial_port_chk
   import sp_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              wdata0,
   input logic              run,
   input logic              rx_en,
   input logic              tx_o,
   input logic              tx_busy,
   input logic              hold_full,
   input logic [7:0]        hold_data,
   input logic              rx_full,
   input logic              ovr,
   input logic              rx_commit
);
   logic wr_tx_c, txrst_c, rxrst_c, rdrx_c;
   assign wr_tx_c = wr_en && (addr == ADDR_W'(W_TXBUF));
   assign txrst_c = wr_en && (addr == ADDR_W'(W_TXRST)) && wdata0;
   assign rxrst_c = wr_en && (addr == ADDR_W'(W_RXRST)) && wdata0;
   assign rdrx_c  = rd_en && (addr == ADDR_W'(W_RXBUF));

   AST_FRAME_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !tx_o); // R3
   AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      hold_full && wr_tx_c |=> hold_data == $past(hold_data)); // R4
   AST_TXRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      txrst_c |=> !hold_full); // R5
   AST_STOPPED_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !tx_busy |=> tx_o && !tx_busy); // R6
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rdrx_c && !rx_commit |=> !rx_full && !ovr); // R9
   AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_commit && rx_full && !rdrx_c && !rxrst_c |=> ovr && rx_full); // R10
   AST_RXOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en && !rx_commit && !rx_full |=> !rx_full); // R11
   AST_RXRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rxrst_c |=> !rx_full && !ovr); // R12
endmodule

bind sp_serial_port sp_serial_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata0(wdata[0]), .run(run), .rx_en(rx_en), .tx_o(tx_o), .tx_busy(tx_busy),
   .hold_full(hold_full), .hold_data(hold_data), .rx_full(rx_full), .ovr(ovr),
   .rx_commit(rx_commit)
);

// File: tb/tb_sp_serial_port.sv
module tb_sp_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tx_o;
   logic        rx_i = 1'b1;

   int nchk = 0, nfail = 0, frames_seen = 0;
   logic [8:0] exp_q[$];   // {parity enabled, byte}

   always #4 clk = ~clk;   // 125 MHz

   sp_serial_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tx_o(tx_o), .rx_i(rx_i)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      bus_read(a, v);
      check(v === exp, tag, v, exp);
   endtask

   task automatic send_rx(input logic [7:0] b, input bit par);
      @(negedge clk); rx_i = 1'b0;
      repeat (32) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_i = b[i];
         repeat (32) @(negedge clk);
      end
      if (par) begin
         rx_i = ~^b;
         repeat (32) @(negedge clk);
      end
      rx_i = 1'b1;
      repeat (48) @(negedge clk);
   endtask

   task automatic wait_frames(input int n);
      while (frames_seen < n) @(posedge clk);
      repeat (40) @(posedge clk);
   endtask

   // line monitor: pops expected frames and compares bit by bit (R3)
   initial begin
      logic [8:0] e;
      logic [7:0] got;
      wait (rst_n);
      forever begin
         @(negedge tx_o);
         repeat (16) @(posedge clk); #1;
         check(tx_o === 1'b0, "R3 start bit", {31'b0, tx_o}, 32'h0);
         for (int i = 0; i < 8; i++) begin
            repeat (32) @(posedge clk); #1;
            got[i] = tx_o;
         end
         if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected frame on line", {24'b0, got}, 32'h0);
            repeat (48) @(posedge clk);
         end else begin
            e = exp_q.pop_front();
            check(got === e[7:0], "R3 data bits", {24'b0, got}, {24'b0, e[7:0]});
            if (e[8]) begin
               repeat (32) @(posedge clk); #1;
               check(tx_o === ~^e[7:0], "R3 odd parity bit", {31'b0, tx_o}, {31'b0, ~^e[7:0]});
            end
            repeat (32) @(posedge clk); #1;
            check(tx_o === 1'b1, "R3 stop bit", {31'b0, tx_o}, 32'h1);
         end
         frames_seen++;
      end
   end

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired (all requirements) actual hung expected done");
      report();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 check(tx_o === 1'b1, "R2 tx idle after reset", {31'b0, tx_o}, 32'h1);
      rst_n = 1'b1;
      expect_reg(4'd5, 32'h0, "R2 status after reset");
      expect_reg(4'd3, 32'h0, "R2 control after reset");
      expect_reg(4'd0, 32'h0, "R2 baud after reset");

      // R1 register readback
      bus_write(4'd0, 32'h0000_0001);
      expect_reg(4'd0, 32'h1, "R1 baud readback");
      bus_write(4'd3, 32'hFFFF_FFFF);
      expect_reg(4'd3, 32'h0000_01AF, "R1 control mask");
      bus_write(4'd4, 32'hFFFF_FFFF);
      expect_reg(4'd4, 32'h0, "R1 interrupt enable reads zero");

      // R6: run clear, byte waits
      bus_write(4'd3, 32'h0000_0129);
      bus_write(4'd1, 32'h0000_005A);
      repeat (200) @(posedge clk);
      #1 check(tx_o === 1'b1, "R6 line idle while stopped", {31'b0, tx_o}, 32'h1);
      expect_reg(4'd5, 32'h200, "R6 byte held while stopped");
      exp_q.push_back({1'b1, 8'h5A});
      bus_write(4'd3, 32'h0000_01A9);
      wait_frames(1);

      // R4: full buffer rejects a write
      exp_q.push_back({1'b1, 8'hA5});
      bus_write(4'd1, 32'h0000_00A5);
      exp_q.push_back({1'b1, 8'h3C});
      bus_write(4'd1, 32'h0000_003C);
      expect_reg(4'd5, 32'h200, "R4 tx full flag");
      bus_write(4'd1, 32'h0000_00C3);
      wait_frames(3);
      repeat (400) @(posedge clk);
      check(frames_seen == 3, "R4 dropped byte not sent", frames_seen, 3);

      // R5: TX reset empties holding buffer
      exp_q.push_back({1'b1, 8'h11});
      bus_write(4'd1, 32'h0000_0011);
      bus_write(4'd1, 32'h0000_0022);
      bus_write(4'd8, 32'h0000_0001);
      expect_reg(4'd5, 32'h0, "R5 tx full cleared by reset");
      wait_frames(4);
      repeat (800) @(posedge clk);
      check(frames_seen == 4, "R5 flushed byte not sent", frames_seen, 4);

      // R3: all-zero data with parity, then no-parity frame
      exp_q.push_back({1'b1, 8'h00});
      bus_write(4'd1, 32'h0000_0000);
      wait_frames(5);
      bus_write(4'd3, 32'h0000_0189);
      exp_q.push_back({1'b0, 8'h81});
      bus_write(4'd1, 32'h0000_0081);
      wait_frames(6);
      check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

      // R7: receive with parity
      bus_write(4'd3, 32'h0000_01A9);
      send_rx(8'h96, 1'b1);
      expect_reg(4'd5, 32'h1, "R7 rx full flag");
      expect_reg(4'd2, 32'h96, "R7 received byte");
      expect_reg(4'd5, 32'h0, "R9 read clears rx full");

      // R8: short start glitch
      @(negedge clk); rx_i = 1'b0;
      repeat (8) @(negedge clk); rx_i = 1'b1;
      repeat (400) @(negedge clk);
      expect_reg(4'd5, 32'h0, "R8 glitch rejected");

      // R10: overrun
      send_rx(8'h12, 1'b1);
      send_rx(8'h34, 1'b1);
      expect_reg(4'd5, 32'h11, "R10 overrun and full");
      expect_reg(4'd2, 32'h34, "R10 newest byte kept");
      expect_reg(4'd5, 32'h0, "R9 read clears overrun");

      // R11: reception disabled
      bus_write(4'd3, 32'h0000_00A9);
      send_rx(8'h77, 1'b1);
      expect_reg(4'd5, 32'h0, "R11 frame ignored while disabled");
      bus_write(4'd3, 32'h0000_01A9);

      // R12: RX reset
      send_rx(8'h55, 1'b1);
      send_rx(8'h66, 1'b1);
      bus_write(4'd9, 32'h0000_0001);
      expect_reg(4'd5, 32'h0, "R12 rx reset clears flags");

      // R7: receive without parity
      bus_write(4'd3, 32'h0000_0189);
      send_rx(8'hC3, 1'b0);
      expect_reg(4'd2, 32'hC3, "R7 received byte no parity");

      report();
   end
endmodule